// File: doc/BRIEF.md
# Single-Channel Block-Input DMA Engine

This block is a bus-master engine that copies a run of words from a small local device store into system memory without CPU involvement per word. The device store is a read-only table inside the block. Software programs the engine with three writes on a narrow port interface: a destination address, a word count, and a go command. It then leaves the engine to run and waits for an interrupt.

After the go command the engine requests the system bus and holds the request for the whole block. On every granted cycle it drives the data, address and control buses together. The data is the current store word, the address is the current destination and the control code is a memory write. It then waits for the memory to acknowledge. Each acknowledge advances the store index and the destination address by one and lowers the remaining count by one. When the count runs out, the engine drops the request, releases the buses and raises an interrupt. The interrupt stays up until software acknowledges it.

Top module: `dma_in_engine`

## Requirements
- R1: Out of reset, the bus request, the interrupt and all three bus output enables are low.
- R2: A port write with select 1 loads the destination address from the port data, and a port write with select 2 loads the word count. Neither write starts a transfer.
- R3: A port write with select 4, made while idle with a nonzero count, raises the bus request in the next cycle. No bus output enable is asserted until the grant input is high.
- R4: In a transfer cycle with the grant high, the data, address and control enables are all high together, and the control bus carries the memory-write code 2'b10. Outside such cycles all three enables are low and the bus outputs are zero.
- R5: Each go clears the store index to zero, and the k-th word of a block is store word k mod 16. Store word i equals (16'h5A5A + i*16'h9E37) mod 2^16.
- R6: The k-th word of a block goes to address start+k, wrapping at the top of the address range. Address, data and count advance only on a cycle where both acknowledge and grant are high, and the bus values stay stable while the engine waits for acknowledge.
- R7: The bus request stays high from the go command until the final word is acknowledged, including any cycles without grant. It drops in the cycle after the final acknowledge, and the interrupt rises in that same cycle.
- R8: The interrupt stays high until the interrupt-acknowledge input is sampled high. The engine is then idle in the next cycle, with the interrupt low.
- R9: A go command with a word count of zero raises the interrupt in the next cycle and never asserts the bus request.
- R10: Port writes of any select are ignored while the engine is not idle. The running block continues with its original addresses and word count.
- R11: When the grant drops in the middle of a block, all enables go low in that same cycle. The transfer resumes at the same unacknowledged word once the grant returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| port_wr_i | input | 1 | Port write strobe |
| port_sel_i | input | 3 | Port select: 1 address, 2 count, 4 go |
| port_data_i | input | 16 | Port write data |
| breq_o | output | 1 | System bus request |
| bgnt_i | input | 1 | System bus grant |
| data_o | output | 16 | Data bus value (zero when not driven) |
| data_oe_o | output | 1 | Data bus drive enable |
| addr_o | output | 16 | Address bus value (zero when not driven) |
| addr_oe_o | output | 1 | Address bus drive enable |
| ctl_o | output | 2 | Control bus code (memory write 2'b10) |
| ctl_oe_o | output | 1 | Control bus drive enable |
| ack_i | input | 1 | Memory write acknowledge |
| irq_o | output | 1 | Completion interrupt |
| irq_ack_i | input | 1 | Interrupt acknowledge |

## Verification
Blocks are run with memory answering at once and with two wait states. The first shows the per-word stepping at full rate. The second shows that nothing advances without acknowledge. A block that starts just below the top of the address range separates correct wrap-around from a saturating or widened address. A grant withdrawn mid-block shows whether the enables follow the grant and whether the unacknowledged word is resent rather than skipped. A zero-count go, and writes made during a busy block to all three ports, show whether the engine gates its port interface on the idle state and handles the empty block without touching the bus.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int PORT_W = 3;
    localparam logic [PORT_W-1:0] PORT_ADDR = 3'd1;
    localparam logic [PORT_W-1:0] PORT_CNT  = 3'd2;
    localparam logic [PORT_W-1:0] PORT_GO   = 3'd4;

    localparam int CTL_W = 2;
    localparam logic [CTL_W-1:0] CTL_MEM_WR = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
    import dma_pkg::*;
(
    input  logic              wr_i,
    input  logic [PORT_W-1:0] sel_i,
    input  logic              idle_i,
    output logic              ld_addr_o,
    output logic              ld_cnt_o,
    output logic              go_o
);
    logic accept;

    always_comb begin
        accept    = wr_i && idle_i;
        ld_addr_o = accept && (sel_i == PORT_ADDR);
        ld_cnt_o  = accept && (sel_i == PORT_CNT);
        go_o      = accept && (sel_i == PORT_GO);
    end
endmodule

// File: rtl/dma_buf_rom.sv
module dma_buf_rom #(
    parameter int                DATA_W = 16,
    parameter int                BUF_AW = 4,
    parameter logic [DATA_W-1:0] SEED   = 16'h5A5A,
    parameter logic [DATA_W-1:0] STEP   = 16'h9E37
) (
    input  logic [BUF_AW-1:0] idx_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int DEPTH = 1 << BUF_AW;

    logic [DATA_W-1:0] table_w [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        assign table_w[gi] = SEED + DATA_W'(gi) * STEP;
    end

    assign word_o = table_w[idx_i];
endmodule

// File: rtl/dma_counters.sv
module dma_counters #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int BUF_AW = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              ld_addr_i,
    input  logic              ld_cnt_i,
    input  logic              go_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] dst_o,
    output logic [BUF_AW-1:0] idx_o,
    output logic              cnt_zero_o,
    output logic              cnt_last_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  left;
        logic [BUF_AW-1:0] idx;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ld_addr_i) begin
            r_d.dst = load_val_i[ADDR_W-1:0];
        end
        if (ld_cnt_i) begin
            r_d.left = load_val_i[CNT_W-1:0];
        end
        if (go_i) begin
            r_d.idx = '0;
        end
        if (step_i) begin
            r_d.dst  = r_q.dst + 1'b1;
            r_d.idx  = r_q.idx + 1'b1;
            r_d.left = r_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dst_o      = r_q.dst;
    assign idx_o      = r_q.idx;
    assign cnt_zero_o = (r_q.left == '0);
    assign cnt_last_o = (r_q.left == CNT_W'(1));
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
    import dma_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic go_i,
    input  logic cnt_zero_i,
    input  logic cnt_last_i,
    input  logic bgnt_i,
    input  logic ack_i,
    input  logic irq_ack_i,
    output logic idle_o,
    output logic breq_o,
    output logic drive_o,
    output logic step_o,
    output logic irq_o
);
    typedef struct packed {
        xfer_state_e st;
    } fsm_regs_t;

    fsm_regs_t f_d, f_q;
    logic      granted_xfer;

    always_comb begin
        f_d          = f_q;
        granted_xfer = (f_q.st == ST_XFER) && bgnt_i;
        step_o       = granted_xfer && ack_i;
        unique case (f_q.st)
            ST_IDLE: begin
                if (go_i) begin
                    f_d.st = cnt_zero_i ? ST_DONE : ST_REQ;
                end
            end
            ST_REQ: begin
                if (bgnt_i) begin
                    f_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (!bgnt_i) begin
                    f_d.st = ST_REQ;
                end else if (ack_i && cnt_last_i) begin
                    f_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                if (irq_ack_i) begin
                    f_d.st = ST_IDLE;
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign idle_o  = (f_q.st == ST_IDLE);
    assign breq_o  = (f_q.st == ST_REQ) || (f_q.st == ST_XFER);
    assign drive_o = granted_xfer;
    assign irq_o   = (f_q.st == ST_DONE);
endmodule

// File: rtl/dma_in_engine.sv
module dma_in_engine
    import dma_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter int                ADDR_W   = 16,
    parameter int                CNT_W    = 16,
    parameter int                BUF_AW   = 4,
    parameter logic [DATA_W-1:0] BUF_SEED = 16'h5A5A,
    parameter logic [DATA_W-1:0] BUF_STEP = 16'h9E37
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              port_wr_i,
    input  logic [2:0]        port_sel_i,
    input  logic [DATA_W-1:0] port_data_i,
    output logic              breq_o,
    input  logic              bgnt_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_oe_o,
    output logic [1:0]        ctl_o,
    output logic              ctl_oe_o,
    input  logic              ack_i,
    output logic              irq_o,
    input  logic              irq_ack_i
);
    logic              idle, ld_addr, ld_cnt, go;
    logic              cnt_zero, cnt_last, step, drive;
    logic [ADDR_W-1:0] dst;
    logic [BUF_AW-1:0] idx;
    logic [DATA_W-1:0] word;

    dma_port_decode u_decode (
        .wr_i      (port_wr_i),
        .sel_i     (port_sel_i),
        .idle_i    (idle),
        .ld_addr_o (ld_addr),
        .ld_cnt_o  (ld_cnt),
        .go_o      (go)
    );

    dma_counters #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .BUF_AW (BUF_AW)
    ) u_counters (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_val_i (port_data_i),
        .ld_addr_i  (ld_addr),
        .ld_cnt_i   (ld_cnt),
        .go_i       (go),
        .step_i     (step),
        .dst_o      (dst),
        .idx_o      (idx),
        .cnt_zero_o (cnt_zero),
        .cnt_last_o (cnt_last)
    );

    dma_buf_rom #(
        .DATA_W (DATA_W),
        .BUF_AW (BUF_AW),
        .SEED   (BUF_SEED),
        .STEP   (BUF_STEP)
    ) u_rom (
        .idx_i  (idx),
        .word_o (word)
    );

    dma_bus_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .go_i       (go),
        .cnt_zero_i (cnt_zero),
        .cnt_last_i (cnt_last),
        .bgnt_i     (bgnt_i),
        .ack_i      (ack_i),
        .irq_ack_i  (irq_ack_i),
        .idle_o     (idle),
        .breq_o     (breq_o),
        .drive_o    (drive),
        .step_o     (step),
        .irq_o      (irq_o)
    );

    always_comb begin
        data_oe_o = drive;
        addr_oe_o = drive;
        ctl_oe_o  = drive;
        data_o    = drive ? word : '0;
        addr_o    = drive ? dst : '0;
        ctl_o     = drive ? CTL_MEM_WR : '0;
    end
endmodule

// File: rtl/dma_in_engine_chk.sv
module dma_in_engine_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              breq_o,
    input logic              bgnt_i,
    input logic              ack_i,
    input logic              irq_o,
    input logic              irq_ack_i,
    input logic              data_oe_o,
    input logic              addr_oe_o,
    input logic              ctl_oe_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        ctl_o
);
    AST_OE_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_oe_o == addr_oe_o) && (addr_oe_o == ctl_oe_o)); // R4

    AST_CTL_WRITE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_oe_o |-> (ctl_o == 2'b10)); // R4

    AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_oe_o |-> breq_o); // R3

    AST_DRIVE_NEEDS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_oe_o |-> bgnt_i); // R11

    AST_ADDR_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_oe_o && !ack_i) |=> (!addr_oe_o || $stable(addr_o))); // R6

    AST_ADDR_STEP_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_oe_o && ack_i) |=> (!addr_oe_o || addr_o == ADDR_W'($past(addr_o) + 1'b1))); // R6

    AST_NO_REQ_AT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> !breq_o); // R7

    AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !irq_ack_i) |=> irq_o); // R8

    AST_IRQ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && irq_ack_i) |=> !irq_o); // R8
endmodule

bind dma_in_engine dma_in_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .breq_o    (breq_o),
    .bgnt_i    (bgnt_i),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .irq_ack_i (irq_ack_i),
    .data_oe_o (data_oe_o),
    .addr_oe_o (addr_oe_o),
    .ctl_oe_o  (ctl_oe_o),
    .addr_o    (addr_o),
    .ctl_o     (ctl_o)
);

// File: tb/dma_in_engine_tb_top.sv
module dma_in_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_wr = 1'b0;
    logic [2:0]  port_sel = '0;
    logic [15:0] port_data = '0;
    logic        breq, bgnt;
    logic [15:0] data_o, addr_o;
    logic        data_oe, addr_oe, ctl_oe;
    logic [1:0]  ctl_o;
    logic        ack_r = 1'b0;
    logic        irq;
    logic        irq_ack = 1'b0;
    logic        grant_block = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int n_done = 0;
    int wait_cycles = 0;
    int wait_cnt = 0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    assign bgnt = breq && !grant_block;

    dma_in_engine dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .port_wr_i   (port_wr),
        .port_sel_i  (port_sel),
        .port_data_i (port_data),
        .breq_o      (breq),
        .bgnt_i      (bgnt),
        .data_o      (data_o),
        .data_oe_o   (data_oe),
        .addr_o      (addr_o),
        .addr_oe_o   (addr_oe),
        .ctl_o       (ctl_o),
        .ctl_oe_o    (ctl_oe),
        .ack_i       (ack_r),
        .irq_o       (irq),
        .irq_ack_i   (irq_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] store_word(input int k);
        return 16'h5A5A + 16'(k % 16) * 16'h9E37;
    endfunction

    task automatic port_write(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        port_wr = 1'b1; port_sel = sel; port_data = val;
        @(negedge clk);
        port_wr = 1'b0;
    endtask

    task automatic push_block(input logic [15:0] start, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            exp_q.push_back({16'(start + 16'(k)), store_word(k)});
        end
    endtask

    task automatic wait_irq(input string req);
        int guard = 0;
        while (!irq && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(irq == 1'b1, req, {31'b0, irq}, 32'd1);
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        chk(irq == 1'b0, "R8 irq after ack", {31'b0, irq}, 32'd0);
    endtask

    // Monitor: memory model and scoreboard consumer
    always @(negedge clk) begin
        if (rst_n) begin
            if (ack_r) begin
                ack_r = 1'b0;
            end else if (data_oe) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected bus write", {addr_o, data_o}, 32'hxxxxxxxx);
                end else begin
                    chk({addr_o, data_o} == exp_q[0], "R5/R6 bus word",
                        {addr_o, data_o}, exp_q[0]);
                    chk(addr_oe && ctl_oe && ctl_o == 2'b10, "R4 enables and code",
                        {29'b0, addr_oe, ctl_o}, 32'h6);
                    if (wait_cnt >= wait_cycles) begin
                        void'(exp_q.pop_front());
                        ack_r = 1'b1;
                        wait_cnt = 0;
                        n_done++;
                    end else begin
                        wait_cnt++;
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk({breq, irq, data_oe, addr_oe, ctl_oe} == 5'b0, "R1 reset outputs",
            {27'b0, breq, irq, data_oe, addr_oe, ctl_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({breq, irq, data_oe} == 3'b0, "R1 after reset",
            {29'b0, breq, irq, data_oe}, 32'd0);

        // R2 R3 R5 R7: 5-word block, zero wait
        port_write(3'd1, 16'h0100);
        port_write(3'd2, 16'd5);
        chk(breq == 1'b0, "R2 loads do not start", {31'b0, breq}, 32'd0);
        push_block(16'h0100, 5);
        port_write(3'd4, 16'h0);
        chk(breq == 1'b1, "R3 request after go", {31'b0, breq}, 32'd1);
        chk(data_oe == 1'b0, "R3 no drive before grant", {31'b0, data_oe}, 32'd0);
        wait_irq("R7 irq at end");
        chk(breq == 1'b0, "R7 request dropped", {31'b0, breq}, 32'd0);
        chk(exp_q.size() == 0, "R2 word count", exp_q.size(), 32'd0);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R8 irq held", {31'b0, irq}, 32'd1);
        clear_irq();

        // R6 wait states and address wrap
        wait_cycles = 2;
        port_write(3'd1, 16'hFFFE);
        port_write(3'd2, 16'd3);
        push_block(16'hFFFE, 3);
        port_write(3'd4, 16'h0);
        wait_irq("R6 irq with wait states");
        chk(exp_q.size() == 0, "R6 all words stalled-block", exp_q.size(), 32'd0);
        clear_irq();

        // R9 zero count
        wait_cycles = 0;
        port_write(3'd2, 16'd0);
        port_write(3'd4, 16'h0);
        chk(irq == 1'b1, "R9 immediate irq", {31'b0, irq}, 32'd1);
        chk(breq == 1'b0, "R9 no request", {31'b0, breq}, 32'd0);
        @(negedge clk);
        chk(breq == 1'b0 && data_oe == 1'b0, "R9 bus untouched", {30'b0, breq, data_oe}, 32'd0);
        clear_irq();

        // R10 port writes ignored while busy
        wait_cycles = 1;
        port_write(3'd1, 16'h0200);
        port_write(3'd2, 16'd4);
        push_block(16'h0200, 4);
        base = n_done;
        port_write(3'd4, 16'h0);
        while (n_done < base + 1) @(negedge clk);
        port_write(3'd1, 16'h0999);
        port_write(3'd2, 16'd7);
        port_write(3'd4, 16'h0);
        wait_irq("R10 block ends");
        chk(n_done - base == 4, "R10 count unchanged", n_done - base, 32'd4);
        chk(exp_q.size() == 0, "R10 queue drained", exp_q.size(), 32'd0);
        repeat (2) @(negedge clk);
        chk(breq == 1'b0, "R10 go ignored while busy", {31'b0, breq}, 32'd0);
        clear_irq();

        // R11 grant loss mid block
        wait_cycles = 0;
        port_write(3'd1, 16'h0300);
        port_write(3'd2, 16'd6);
        push_block(16'h0300, 6);
        base = n_done;
        port_write(3'd4, 16'h0);
        while (n_done < base + 2) @(negedge clk);
        @(posedge clk); #1 grant_block = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk({data_oe, addr_oe, ctl_oe} == 3'b0, "R11 enables off without grant",
                {29'b0, data_oe, addr_oe, ctl_oe}, 32'd0);
            chk(breq == 1'b1, "R7 request held without grant", {31'b0, breq}, 32'd1);
        end
        @(posedge clk); #1 grant_block = 1'b0;
        wait_irq("R11 block resumes");
        chk(n_done - base == 6, "R11 words after resume", n_done - base, 32'd6);
        chk(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 32'd0);
        clear_irq();

        summary();
        $finish;
    end
endmodule